// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Model

This block models the slave side of a two-wire serial EEPROM whose bus lines are not real pins but levels that a host writes as register bits. On every write strobe the host hands over a new clock/data pair. The block compares it with the previous pair to find start conditions, stop conditions, clock rises and clock falls. A bit-cycle counter advances on each clock rise while a transfer is open. Incoming bits are taken on clock falls and go into the device byte, the word address or the addressed byte of an internal array. A read strobe returns the serial data-out level that the slave would drive, registered one clock later.

The counter is absolute: it runs from 0 after a start and folds back to a fixed earlier value at the end of each data byte, so a sequential transfer stays in its data window. A static parameter selects one of three addressing schemes. The legacy scheme has a 128-byte array and one combined address/direction byte. The standard scheme takes a device byte followed by either one or two word-address bytes.

Top module: `eep_slave`

## Requirements
- R1: After reset the read result is 0, no transfer is open, the last SDA level is taken as 1, and every array byte holds 0xFF.
- R2: A write with SCL high in both the old and new pair and SDA falling opens a transfer and sets the counter to 0; SCL high in both with SDA rising closes it. While open, each SCL rise adds one to the counter before the cycle is processed. A read with no transfer open returns the last SDA level written.
- R3: A read while the counter stands at 9, 18 or 27 returns 0 (acknowledge).
- R4: Legacy mode, writing: the bits taken on falls in cycles 1–8 form a byte MSB first, {word address[6:0], direction}, direction 0 = write. Data bits of cycles 10–17 are shifted into the addressed byte MSB first. After cycle 17 only word-address bits 1:0 advance, so writes wrap inside a 4-byte page. The counter folds from 18 to 9.
- R5: Legacy mode, direction 1: a read in cycles 10–17 returns bit (17 − counter) of the addressed byte; on the fold from 18 to 9 the word address advances by one modulo 128.
- R6: Standard one-byte mode: cycles 1–8 give the device byte (bit 0 = 1 means read), cycles 10–17 the word address. When that byte completes, device bits 3:1 become address bits 10:8. Data uses cycles 19–26 and the counter folds from 27 to 18.
- R7: Standard two-byte mode: cycles 10–17 give the high and 19–26 the low address byte of a 13-bit address. Data uses cycles 28–35 and the counter folds from 36 to 27. The array is indexed by the low MEM_AW address bits.
- R8: Standard write: when a data byte completes only address bits 3:0 advance, giving a 16-byte page wrap.
- R9: Standard read: in cycles 10–17 a read returns bit (17 − counter) of the byte at the address left by an earlier write phase (random read through a repeated start). At 18 the counter folds to 9 and the full address advances by one.
- R10: The read result for a read strobe appears after the next clock edge and holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe: present a new SCL/SDA pair |
| wrScl | input | 1 | SCL level carried by the write |
| wrSda | input | 1 | SDA level carried by the write |
| rdEn | input | 1 | Read strobe for the slave data-out level |
| rdData | output | 1 | Registered slave data-out level |

## Verification
Every bus event takes effect at the clock edge that samples its write strobe, and the data-out level for a read strobe is due exactly one edge later and must then hold. The bench drives strobes on falling clock edges and updates its behavioural model at the same moment. It compares the output with the model a few nanoseconds after every rising edge, so each comparison lands after the one register stage on the read path. On top of the per-clock comparison, whole bytes read back are checked against constants derived by hand from the page-wrap, address-fold and device-bit rules.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int MODE_LEGACY  = 0;
  localparam int MODE_STD_A8  = 1;
  localparam int MODE_STD_A16 = 2;

  localparam int CYC_W = 6;   // bit-cycle counter width (max 36)
  localparam int ADR_W = 13;  // widest word address
  localparam int DEV_W = 4;   // kept device-byte bits (3:0)

  // strobes from control to datapath
  typedef struct packed {
    logic riseEv;
    logic fallEv;
    logic rdAdvance;
    logic bitIn;
  } eepStrobe_t;

  // last cycle of a data byte for each addressing scheme
  function automatic int lastDataCyc(int mode);
    return (mode == MODE_LEGACY) ? 17 : ((mode == MODE_STD_A8) ? 26 : 35);
  endfunction
endpackage

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int MODE = MODE_STD_A8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrScl,
  input  logic             wrSda,
  input  logic             isRead,
  output eepStrobe_t       stb,
  output logic             started,
  output logic [CYC_W-1:0] cyc,
  output logic             sdaLast
);
  localparam int LAST_DATA = lastDataCyc(MODE);

  logic             sclQ;
  logic             startEv;
  logic             stopEv;
  logic             rdWrap;
  logic [CYC_W-1:0] cycInc;
  logic [CYC_W-1:0] cycNext;

  always_comb begin
    startEv       = wrEn & sclQ & wrScl & sdaLast & ~wrSda;
    stopEv        = wrEn & sclQ & wrScl & ~sdaLast & wrSda;
    stb.riseEv    = wrEn & started & ~sclQ & wrScl;
    stb.fallEv    = wrEn & started & sclQ & ~wrScl;
    stb.bitIn     = wrSda;
    cycInc        = cyc + CYC_W'(1);
    rdWrap        = isRead && (cycInc == CYC_W'(18));
    stb.rdAdvance = rdWrap;
    if (rdWrap)
      cycNext = CYC_W'(9);
    else if (cycInc == CYC_W'(LAST_DATA + 1))
      cycNext = CYC_W'(LAST_DATA - 8);
    else
      cycNext = cycInc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ    <= 1'b1;
      sdaLast <= 1'b1;
      started <= 1'b0;
      cyc     <= '0;
    end else if (wrEn) begin
      sclQ    <= wrScl;
      sdaLast <= wrSda;
      if (startEv) begin
        started <= 1'b1;
        cyc     <= '0;
      end else if (stopEv) begin
        started <= 1'b0;
      end else if (stb.riseEv) begin
        cyc <= cycNext;
      end
    end
  end
endmodule

// File: rtl/eep_dpath.sv
module eep_dpath
  import eep_pkg::*;
#(
  parameter int MODE   = MODE_STD_A8,
  parameter int MEM_AW = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  eepStrobe_t       stb,
  input  logic             started,
  input  logic [CYC_W-1:0] cyc,
  input  logic             sdaLast,
  input  logic             rdEn,
  output logic             isRead,
  output logic             rdData
);
  localparam bit LEGACY    = (MODE == MODE_LEGACY);
  localparam int IDX_W     = LEGACY ? 7 : MEM_AW;
  localparam int DEPTH     = 1 << IDX_W;
  localparam int LAST_DATA = lastDataCyc(MODE);
  localparam int ADDR_KEEP = (MODE == MODE_STD_A16) ? ADR_W : 8;
  localparam logic [ADR_W-1:0] ADDR_MASK = ADR_W'((1 << ADDR_KEEP) - 1);

  logic [ADR_W-1:0] addrQ, addrD, shifted;
  logic [DEV_W-1:0] devQ, devD;
  logic [7:0]       mem [DEPTH];
  logic [IDX_W-1:0] idx;
  logic [7:0]       curByte;
  logic             memWe;
  logic             isAck;
  logic             inData;
  logic [2:0]       bitSel;
  logic             readBit;

  generate
    if (LEGACY) begin : g_legacy
      assign idx    = addrQ[7:1];
      assign isRead = addrQ[0];
    end else begin : g_std
      assign idx    = addrQ[IDX_W-1:0];
      assign isRead = devQ[0];
    end
  endgenerate

  assign curByte = mem[idx];
  assign isAck   = (cyc == CYC_W'(9)) || (cyc == CYC_W'(18)) || (cyc == CYC_W'(27));
  assign inData  = (cyc >= CYC_W'(10)) && (cyc <= CYC_W'(17));
  assign bitSel  = 3'(CYC_W'(17) - cyc);
  assign shifted = {addrQ[ADR_W-2:0], stb.bitIn} & ADDR_MASK;

  // bit decoding on SCL fall, address advance on read fold
  always_comb begin
    addrD = addrQ;
    devD  = devQ;
    memWe = 1'b0;
    if (stb.riseEv && stb.rdAdvance) begin
      addrD = LEGACY ? ((addrQ + ADR_W'(2)) & ADDR_MASK) : (addrQ + ADR_W'(1));
    end else if (stb.fallEv) begin
      if (LEGACY) begin
        if (cyc > CYC_W'(9)) begin
          if (!addrQ[0]) begin
            memWe = 1'b1;
            if (cyc == CYC_W'(17)) addrD[2:1] = addrQ[2:1] + 2'd1;
          end
        end else if (cyc < CYC_W'(9)) begin
          addrD = shifted;
        end
      end else if (!isAck) begin
        if (cyc > CYC_W'(LAST_DATA - 8)) begin
          if (!devQ[0]) begin
            memWe = 1'b1;
            if (cyc == CYC_W'(LAST_DATA)) addrD[3:0] = addrQ[3:0] + 4'd1;
          end
        end else if (cyc > CYC_W'(9)) begin
          if (!devQ[0]) begin
            addrD = shifted;
            if (MODE == MODE_STD_A8 && cyc == CYC_W'(17)) addrD[10:8] = devQ[3:1];
          end
        end else begin
          devD = {devQ[DEV_W-2:0], stb.bitIn};
        end
      end
    end
  end

  always_comb begin
    if (!started)             readBit = sdaLast;
    else if (isAck)           readBit = 1'b0;
    else if (inData && isRead) readBit = curByte[bitSel];
    else                      readBit = sdaLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      devQ   <= '0;
      rdData <= 1'b0;
    end else begin
      addrQ <= addrD;
      devQ  <= devD;
      if (rdEn) rdData <= readBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (memWe) begin
      mem[idx] <= {curByte[6:0], stb.bitIn};
    end
  end
endmodule

// File: rtl/eep_slave.sv
module eep_slave
  import eep_pkg::*;
#(
  parameter int MODE   = MODE_STD_A8,
  parameter int MEM_AW = 11
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic wrScl,
  input  logic wrSda,
  input  logic rdEn,
  output logic rdData
);
  eepStrobe_t       stb;
  logic             started;
  logic [CYC_W-1:0] cyc;
  logic             sdaLast;
  logic             isRead;

  eep_ctrl #(.MODE(MODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrScl(wrScl), .wrSda(wrSda),
    .isRead(isRead), .stb(stb), .started(started), .cyc(cyc), .sdaLast(sdaLast)
  );

  eep_dpath #(.MODE(MODE), .MEM_AW(MEM_AW)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .started(started), .cyc(cyc),
    .sdaLast(sdaLast), .rdEn(rdEn), .isRead(isRead), .rdData(rdData)
  );
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk
  import eep_pkg::*;
#(
  parameter int MODE = MODE_STD_A8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             wrScl,
  input logic             wrSda,
  input logic             rdEn,
  input logic             rdData,
  input eepStrobe_t       stb,
  input logic             started,
  input logic [CYC_W-1:0] cyc,
  input logic             sdaLast
);
  localparam int LAST_DATA = lastDataCyc(MODE);

  // R2
  open_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(started) |-> $past(wrEn && wrScl && !wrSda) && cyc == '0);

  // R2
  close_on_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(started) |-> $past(wrEn && wrScl && wrSda));

  // R2
  count_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.riseEv |=> $stable(cyc) || cyc == '0);

  // R7
  cycle_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    started |-> cyc <= CYC_W'(LAST_DATA));

  // R9
  read_fold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.riseEv && stb.rdAdvance |=> cyc == CYC_W'(9));

  // R3
  ack_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && started && cyc == CYC_W'(9) |=> !rdData);

  // R2
  idle_echo_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && !started |=> rdData == $past(sdaLast));

  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));
endmodule

bind eep_slave eep_slave_chk #(.MODE(MODE)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrScl(wrScl), .wrSda(wrSda),
  .rdEn(rdEn), .rdData(rdData), .stb(stb), .started(started), .cyc(cyc),
  .sdaLast(sdaLast)
);

// File: tb/eep_slave_tb.sv
`timescale 1ns/1ps
module eep_slave_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] wrEn = '0, wrScl = '1, wrSda = '1, rdEn = '0;
  logic [2:0] rdData;

  int    tests = 0;
  int    fails = 0;
  bit    expRd [3];
  string curTag [3];
  bit    finished = 0;

  // behavioural reference state, one set per instance
  int mCyc [3], mAddr [3], mDev [3];
  bit mStart [3], mScl [3], mSda [3];
  int mMem [3][2048];
  int dep   [3] = '{128, 2048, 256};
  int lastD [3] = '{17, 26, 35};

  always #4 clk = ~clk;  // 125 MHz

  eep_slave #(.MODE(0), .MEM_AW(11)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn[0]), .wrScl(wrScl[0]), .wrSda(wrSda[0]),
    .rdEn(rdEn[0]), .rdData(rdData[0]));
  eep_slave #(.MODE(1), .MEM_AW(11)) u_dut_a8 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn[1]), .wrScl(wrScl[1]), .wrSda(wrSda[1]),
    .rdEn(rdEn[1]), .rdData(rdData[1]));
  eep_slave #(.MODE(2), .MEM_AW(8)) u_dut_a16 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn[2]), .wrScl(wrScl[2]), .wrSda(wrSda[2]),
    .rdEn(rdEn[2]), .rdData(rdData[2]));

  function automatic int memIdx(int m);
    return (m == 0) ? ((mAddr[m] >> 1) & 127) : (mAddr[m] & (dep[m] - 1));
  endfunction

  function automatic bit isRd(int m);
    return (m == 0) ? mAddr[m][0] : mDev[m][0];
  endfunction

  task automatic modelWrite(int m, bit scl, bit sda);
    int c;
    bit rd = isRd(m);
    if (mScl[m] && scl) begin
      if (mSda[m] && !sda) begin mCyc[m] = 0; mStart[m] = 1; end
      else if (!mSda[m] && sda) mStart[m] = 0;
    end else if (mStart[m] && !mScl[m] && scl) begin
      mCyc[m]++;
      if (rd && mCyc[m] == 18) begin
        mCyc[m] = 9;
        mAddr[m] = (m == 0) ? ((mAddr[m] + 2) & 255) : ((mAddr[m] + 1) & 8191);
      end else if (mCyc[m] == lastD[m] + 1) mCyc[m] = lastD[m] - 8;
    end else if (mStart[m] && mScl[m] && !scl) begin
      c = mCyc[m];
      if (m == 0) begin
        if (c > 9) begin
          if (!rd) begin
            mMem[m][memIdx(m)] = ((mMem[m][memIdx(m)] << 1) | sda) & 255;
            if (c == 17) mAddr[m] = (mAddr[m] & 'hF9) | ((mAddr[m] + 2) & 6);
          end
        end else if (c < 9) mAddr[m] = ((mAddr[m] << 1) | sda) & 255;
      end else if (c == 9 || c == 18 || c == 27) begin
      end else if (c > lastD[m] - 8) begin
        if (!rd) begin
          mMem[m][memIdx(m)] = ((mMem[m][memIdx(m)] << 1) | sda) & 255;
          if (c == lastD[m]) mAddr[m] = (mAddr[m] & ~15) | ((mAddr[m] + 1) & 15);
        end
      end else if (c > 9) begin
        if (!rd) begin
          mAddr[m] = ((mAddr[m] << 1) | sda) & ((m == 1) ? 255 : 8191);
          if (c == 17 && m == 1) mAddr[m] = (mAddr[m] & 255) | ((mDev[m] << 7) & 'h700);
        end
      end else mDev[m] = ((mDev[m] << 1) | sda) & 255;
    end
    mScl[m] = scl;
    mSda[m] = sda;
  endtask

  function automatic bit modelRead(int m);
    int c = mCyc[m];
    if (!mStart[m]) return mSda[m];
    if (c == 9 || c == 18 || c == 27) return 1'b0;
    if (c >= 10 && c <= 17 && isRd(m)) return 1'((mMem[m][memIdx(m)] >> (17 - c)) & 1);
    return mSda[m];
  endfunction

  // per-clock comparison with the model
  always @(posedge clk) begin
    #3;
    if (!finished) begin
      for (int m = 0; m < 3; m++) begin
        tests++;
        if (rdData[m] !== expRd[m]) begin
          fails++;
          $display("FAIL %s dut%0d rdData=%0b expected %0b", curTag[m], m, rdData[m], expRd[m]);
        end
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic hw(int m, bit scl, bit sda);
    @(negedge clk);
    wrEn[m] = 1'b1; wrScl[m] = scl; wrSda[m] = sda;
    modelWrite(m, scl, sda);
    @(negedge clk);
    wrEn[m] = 1'b0;
  endtask

  task automatic hread(int m, string tag, output bit v);
    @(negedge clk);
    rdEn[m] = 1'b1;
    expRd[m] = modelRead(m);
    curTag[m] = tag;
    @(negedge clk);
    rdEn[m] = 1'b0;
    v = rdData[m];
  endtask

  task automatic startCond(int m);
    hw(m, 1, 1); hw(m, 1, 0); hw(m, 0, 0);
  endtask

  task automatic stopCond(int m);
    hw(m, 0, 0); hw(m, 1, 0); hw(m, 1, 1);
  endtask

  task automatic sendBit(int m, bit b);
    hw(m, 0, b); hw(m, 1, b); hw(m, 0, b);
  endtask

  task automatic sendByte(int m, logic [7:0] b);
    bit a;
    for (int i = 7; i >= 0; i--) sendBit(m, b[i]);
    hw(m, 0, 1); hw(m, 1, 1);
    hread(m, "R3", a);
    chk("R3 ack", a, 0);
    hw(m, 0, 1);
  endtask

  task automatic readByte(int m, string tag, output int v);
    bit b;
    v = 0;
    for (int i = 0; i < 8; i++) begin
      hw(m, 0, 1); hw(m, 1, 1);
      hread(m, tag, b);
      v = (v << 1) | b;
      hw(m, 0, 1);
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v;
    bit b;
    for (int m = 0; m < 3; m++) begin
      mCyc[m] = 0; mAddr[m] = 0; mDev[m] = 0;
      mStart[m] = 0; mScl[m] = 1; mSda[m] = 1;
      expRd[m] = 0; curTag[m] = "R1";
      for (int i = 0; i < 2048; i++) mMem[m][i] = 255;
    end
    repeat (3) @(negedge clk);
    chk("R1 reset rdData", int'(rdData), 0);
    rstN = 1'b1;

    // R2: idle reads echo the last SDA written
    hread(0, "R2", b); chk("R2 idle echo after reset", b, 1);
    hw(0, 0, 0);
    hread(0, "R2", b); chk("R2 idle echo low", b, 0);
    hw(0, 1, 1);

    // R4: legacy write of 5 bytes from word 5, page wraps at 4
    startCond(0);
    sendByte(0, 8'h0A);
    sendByte(0, 8'h11); sendByte(0, 8'h22); sendByte(0, 8'h33);
    sendByte(0, 8'h44); sendByte(0, 8'h55);
    stopCond(0);
    hread(0, "R2", b); chk("R2 echo after stop", b, 1);

    // R5: legacy sequential read from word 4
    startCond(0);
    sendByte(0, 8'h09);
    readByte(0, "R5", v); chk("R4 word4", v, 'h44); sendBit(0, 0);
    readByte(0, "R5", v); chk("R4 word5", v, 'h55); sendBit(0, 0);
    readByte(0, "R5", v); chk("R4 word6", v, 'h22); sendBit(0, 0);
    readByte(0, "R5", v); chk("R4 word7", v, 'h33); sendBit(0, 0);
    readByte(0, "R5", v); chk("R1 erased word8", v, 'hFF); sendBit(0, 1);
    stopCond(0);

    // R5: read across the top of the 128-byte array
    startCond(0); sendByte(0, 8'hFE); sendByte(0, 8'hA5); stopCond(0);
    startCond(0); sendByte(0, 8'h00); sendByte(0, 8'h5A); stopCond(0);
    startCond(0);
    sendByte(0, 8'hFF);
    readByte(0, "R5", v); chk("R5 word7F", v, 'hA5); sendBit(0, 0);
    readByte(0, "R5", v); chk("R5 wrap to word0", v, 'h5A); sendBit(0, 1);
    stopCond(0);

    // R6 / R8: one-byte standard, device bits give address 10:8, 17 bytes wrap page
    startCond(1);
    sendByte(1, 8'hA6);
    sendByte(1, 8'h3E);
    for (int i = 0; i <= 16; i++) sendByte(1, 8'(8'h80 + i));
    stopCond(1);

    // R9: random read through repeated start
    startCond(1);
    sendByte(1, 8'hA6);
    sendByte(1, 8'h3E);
    startCond(1);
    sendByte(1, 8'hA7);
    readByte(1, "R9", v); chk("R8 page wrap 0x33E", v, 'h90); sendBit(1, 0);
    readByte(1, "R9", v); chk("R6 addr 0x33F", v, 'h81); sendBit(1, 0);
    readByte(1, "R9", v); chk("R9 linear advance 0x340", v, 'hFF); sendBit(1, 1);
    stopCond(1);
    startCond(1);
    sendByte(1, 8'hA6);
    sendByte(1, 8'h30);
    startCond(1);
    sendByte(1, 8'hA7);
    readByte(1, "R8", v); chk("R8 0x330", v, 'h82); sendBit(1, 1);
    stopCond(1);

    // R7: two-byte standard, address 0x12F8
    startCond(2);
    sendByte(2, 8'hA0); sendByte(2, 8'h12); sendByte(2, 8'hF8);
    sendByte(2, 8'hC1); sendByte(2, 8'hC2); sendByte(2, 8'hC3);
    stopCond(2);
    startCond(2);
    sendByte(2, 8'hA0); sendByte(2, 8'h12); sendByte(2, 8'hF8);
    startCond(2);
    sendByte(2, 8'hA1);
    readByte(2, "R7", v); chk("R7 0x12F8", v, 'hC1); sendBit(2, 0);
    readByte(2, "R7", v); chk("R7 0x12F9", v, 'hC2); sendBit(2, 0);
    readByte(2, "R7", v); chk("R7 0x12FA", v, 'hC3); sendBit(2, 1);
    stopCond(2);

    // R10: result holds across idle clocks
    hread(2, "R10", b);
    repeat (4) @(negedge clk);
    chk("R10 hold", int'(rdData[2]), int'(b));

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule